// File: doc/BRIEF.md
# GPIO Bank with Single-Edge Interrupts

This block is a bank of general-purpose pins behind a small word-addressed register bus. Each pin has an output enable and an output value, and its level can be read back. The registers for a bank wider than 32 pins are split across two 32-bit words: the lower word holds pins 0 to 31 and the next word holds the rest. Every pin input passes through a two-flop synchronizer.

Each pin has an edge detector that reacts to one edge direction only. A per-pin polarity bit selects rising or falling. A detected edge sets a sticky status bit, and software clears it by writing a one. Enabled pending bits drive the `irq` output. Enabled pending bits that are also marked for wake drive the `wake` output.

Software can emulate both-edge operation by flipping the polarity bit after each event. To do this it compares the synchronized input level, readable at any time, with the stored polarity. Writing the polarity never raises an event by itself, so a stale polarity shows up only through that comparison.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every register reads 0. Every pin is an input (`pin_oe` all 0), every interrupt is disabled, every polarity selects rising, and `irq` and `wake` are 0.
- R2: In the pin region, direction sits at word 0/1 and drive value at word 6/7, with 1 in the direction bit meaning output. These drive `pin_oe` and `pin_out` directly. Pins 0..31 are in the even word and pins 32 and up are in the odd word, at the same bit position minus 32.
- R3: Register bits for pin indices at or above NUM_PINS read 0 and cannot be written.
- R4: Pin-region words 4/5 return the synchronized level of every pin whatever its direction. The level is readable no later than 3 clock edges after the pin changes, and writes to these words have no effect.
- R5: Polarity (interrupt region words 2/3) 0 sets the pin's status bit on a rising synchronized edge only.
- R6: Polarity 1 sets the pin's status bit on a falling synchronized edge only.
- R7: Status (interrupt region words 4/5) is sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: An edge detected in the same cycle as a clearing write to that bit leaves the bit set.
- R9: Writing the polarity register never sets a status bit, even when the new polarity disagrees with the current level.
- R10: `irq` is 1 exactly when some status bit has its enable bit (interrupt region words 0/1) set. A status bit latches even while its enable is 0.
- R11: `wake` is 1 exactly when some status bit has both its enable bit and its wake bit (interrupt region words 6/7) set.
- R12: The output-control word (pin-region words 8/9) stores and reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_region | input | 1 | 0 selects pin registers, 1 selects interrupt registers |
| bus_word | input | 4 | 32-bit word index inside the region (bit 0 picks the upper pin word) |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output drive value |
| pin_oe | output | NUM_PINS | Output enable per pin |
| irq | output | 1 | Any enabled pending event |
| wake | output | 1 | Any enabled, wake-marked pending event |

## Verification
The bench builds the block with NUM_PINS = 36, which is the default. With that width the upper word is only partly populated: pins 32..35 exercise the odd-word split, and bits 4..31 of each odd word exercise the masking of absent pins. Edge, polarity and clear sequences run on pin 34 in the upper word. The write-versus-edge collision is placed on the exact edge where the event lands, which is three clock edges after the pin changes.

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int NUM_PINS = 36
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_region,
  input  logic [3:0]          bus_word,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq,
  output logic                wake
);
  localparam int W = 64;
  localparam logic [W-1:0] PIN_MASK = (NUM_PINS >= W) ? {W{1'b1}} : ((W'(1) << NUM_PINS) - W'(1));

  localparam logic [2:0] P_OE   = 3'd0;
  localparam logic [2:0] P_IN   = 3'd2;
  localparam logic [2:0] P_OV   = 3'd3;
  localparam logic [2:0] P_OCTL = 3'd4;
  localparam logic [2:0] I_EN   = 3'd0;
  localparam logic [2:0] I_POL  = 3'd1;
  localparam logic [2:0] I_ST   = 3'd2;
  localparam logic [2:0] I_WK   = 3'd3;

  logic [W-1:0] oe_q, ov_q, octl_q, en_q, pol_q, st_q, wk_q;
  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [W-1:0] pin_ext, ev, clr;
  logic [W-1:0] wr_word;
  logic [W-1:0] rd_sel;
  logic         hi;
  logic [2:0]   grp;

  assign hi      = bus_word[0];
  assign grp     = bus_word[3:1];
  assign pin_ext = W'(pin_in);
  assign wr_word = hi ? {bus_wdata, 32'b0} : {32'b0, bus_wdata};

  function automatic logic [W-1:0] merge(input logic [W-1:0] cur, input logic upper,
                                         input logic [31:0] d);
    merge = (upper ? {d, cur[31:0]} : {cur[63:32], d}) & PIN_MASK;
  endfunction

  wire wr_pin = bus_wr && !bus_region;
  wire wr_irq = bus_wr &&  bus_region;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_ext & PIN_MASK;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign ev  = (sync_q ^ prev_q) & (sync_q ^ pol_q) & PIN_MASK;
  assign clr = (wr_irq && grp == I_ST) ? wr_word : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_q   <= '0;
      ov_q   <= '0;
      octl_q <= '0;
      en_q   <= '0;
      pol_q  <= '0;
      wk_q   <= '0;
      st_q   <= '0;
    end else begin
      if (wr_pin && grp == P_OE)   oe_q   <= merge(oe_q,   hi, bus_wdata);
      if (wr_pin && grp == P_OV)   ov_q   <= merge(ov_q,   hi, bus_wdata);
      if (wr_pin && grp == P_OCTL) octl_q <= merge(octl_q, hi, bus_wdata);
      if (wr_irq && grp == I_EN)   en_q   <= merge(en_q,   hi, bus_wdata);
      if (wr_irq && grp == I_POL)  pol_q  <= merge(pol_q,  hi, bus_wdata);
      if (wr_irq && grp == I_WK)   wk_q   <= merge(wk_q,   hi, bus_wdata);
      st_q <= ((st_q & ~clr) | ev) & PIN_MASK;
    end
  end

  always_comb begin
    rd_sel = '0;
    if (!bus_region) begin
      case (grp)
        P_OE:    rd_sel = oe_q;
        P_IN:    rd_sel = sync_q;
        P_OV:    rd_sel = ov_q;
        P_OCTL:  rd_sel = octl_q;
        default: rd_sel = '0;
      endcase
    end else begin
      case (grp)
        I_EN:    rd_sel = en_q;
        I_POL:   rd_sel = pol_q;
        I_ST:    rd_sel = st_q;
        I_WK:    rd_sel = wk_q;
        default: rd_sel = '0;
      endcase
    end
  end

  assign bus_rdata = hi ? rd_sel[63:32] : rd_sel[31:0];
  assign pin_out   = ov_q[NUM_PINS-1:0];
  assign pin_oe    = oe_q[NUM_PINS-1:0];
  assign irq       = |(st_q & en_q);
  assign wake      = |(st_q & en_q & wk_q);
endmodule

module gpio_edge_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr_wr,
  input logic [63:0] sync_v,
  input logic [63:0] prev_v,
  input logic [63:0] pol_v,
  input logic [63:0] st_v,
  input logic        irq,
  input logic        wake
);
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((st_v & $past(st_v)) == $past(st_v))); // R7

  AST_EDGE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_v & ~$past(st_v) &
      ~(($past(sync_v) & ~$past(prev_v) & ~$past(pol_v)) |
        (~$past(sync_v) & $past(prev_v) & $past(pol_v)))) == 64'b0)); // R5

  AST_NO_EVENT_WITHOUT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_v == prev_v) |=> ((st_v & ~$past(st_v)) == 64'b0)); // R9

  AST_WAKE_IMPLIES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> irq); // R11

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st_v != 64'b0)); // R10
endmodule

bind gpio_edge_bank gpio_edge_bank_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .clr_wr (wr_irq && grp == I_ST),
  .sync_v (sync_q),
  .prev_v (prev_q),
  .pol_v  (pol_q),
  .st_v   (st_q),
  .irq    (irq),
  .wake   (wake)
);

// File: tb/gpio_edge_bank_tb.sv
module gpio_edge_bank_tb;
  localparam int NP = 36;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_region = 1'b0;
  logic [3:0]    bus_word = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq, wake;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  gpio_edge_bank #(.NUM_PINS(NP)) u_dut (.*);

  // table entries: {polarity, new level of pin 34, expect status bit set}
  localparam logic [2:0] VEC [8] = '{3'b011, 3'b000, 3'b110, 3'b101,
                                     3'b000, 3'b100, 3'b110, 3'b010};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic rg, input logic [3:0] w, input logic [31:0] d);
    @(negedge clk);
    bus_region = rg; bus_word = w; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic rg, input logic [3:0] w, output logic [31:0] d);
    @(negedge clk);
    bus_region = rg; bus_word = w;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int w = 0; w < 10; w++) begin
      rd(1'b0, 4'(w), d); chk("R1 pin reg", 64'(d), 64'd0);
    end
    for (int w = 0; w < 8; w++) begin
      rd(1'b1, 4'(w), d); chk("R1 irq reg", 64'(d), 64'd0);
    end
    chk("R1 pin_oe", 64'(pin_oe), 64'd0);
    chk("R1 irq/wake", {62'd0, irq, wake}, 64'd0);

    // R2 direction/drive and word split
    wr(1'b0, 4'd0, 32'h0000_00A5);
    wr(1'b0, 4'd1, 32'h0000_0009);
    @(negedge clk);
    chk("R2 pin_oe", 64'(pin_oe), 64'h9_0000_00A5);
    wr(1'b0, 4'd7, 32'h0000_0006);
    @(negedge clk);
    chk("R2 pin_out hi word", 64'(pin_out), 64'h6_0000_0000);
    // R3 absent pins masked
    wr(1'b0, 4'd1, 32'hFFFF_FFFF);
    rd(1'b0, 4'd1, d); chk("R3 oe hi masked", 64'(d), 64'hF);
    // R12 output control
    wr(1'b0, 4'd8, 32'h1234_5678);
    rd(1'b0, 4'd8, d); chk("R12 octl", 64'(d), 64'h1234_5678);

    // R4 input level independent of direction, read-only
    @(negedge clk); pin_in = 36'hA_0000_00F0;
    settle();
    rd(1'b0, 4'd4, d); chk("R4 in lo", 64'(d), 64'h0000_00F0);
    rd(1'b0, 4'd5, d); chk("R4 in hi", 64'(d), 64'hA);
    wr(1'b0, 4'd4, 32'h0);
    rd(1'b0, 4'd4, d); chk("R4 in read-only", 64'(d), 64'h0000_00F0);
    @(negedge clk); pin_in = '0;
    settle();
    wr(1'b1, 4'd4, 32'hFFFF_FFFF);
    wr(1'b1, 4'd5, 32'hFFFF_FFFF);

    // R5/R6/R9/R7 table on pin 34 (upper word bit 2)
    foreach (VEC[i]) begin
      wr(1'b1, 4'd3, VEC[i][2] ? 32'h4 : 32'h0);
      @(negedge clk); pin_in[34] = VEC[i][1];
      settle();
      rd(1'b1, 4'd5, d);
      chk($sformatf("R5 R6 R9 step %0d", i), 64'(d[2]), 64'(VEC[i][0]));
      wr(1'b1, 4'd5, 32'h0);
      rd(1'b1, 4'd5, d);
      chk("R7 write 0 keeps", 64'(d[2]), 64'(VEC[i][0]));
      wr(1'b1, 4'd5, 32'h4);
      rd(1'b1, 4'd5, d);
      chk("R7 write 1 clears", 64'(d[2]), 64'd0);
    end
    wr(1'b1, 4'd3, 32'h0);
    @(negedge clk); pin_in[34] = 1'b0;
    settle();
    wr(1'b1, 4'd5, 32'hFFFF_FFFF);

    // R8 edge and clear in the same cycle on pin 0
    @(negedge clk); pin_in[0] = 1'b1; settle();
    @(negedge clk); pin_in[0] = 1'b0; settle();
    @(negedge clk); pin_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_region = 1'b1; bus_word = 4'd4; bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(1'b1, 4'd4, d); chk("R8 edge beats clear", 64'(d[0]), 64'd1);

    // R10 enable gating
    chk("R10 irq off while disabled", 64'(irq), 64'd0);
    wr(1'b1, 4'd0, 32'h1);
    @(negedge clk);
    chk("R10 irq on when enabled", 64'(irq), 64'd1);
    chk("R11 wake off when unmarked", 64'(wake), 64'd0);
    wr(1'b1, 4'd6, 32'h1);
    @(negedge clk);
    chk("R11 wake on when marked", 64'(wake), 64'd1);
    wr(1'b1, 4'd4, 32'h1);
    @(negedge clk);
    chk("R10 irq after clear", {62'd0, irq, wake}, 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule